// File: doc/BRIEF.md
# Multi-Beat Wide Load/Store Unit

This unit executes every memory instruction of a 32-bit MIPS-style integer core whose registers also have a 128-bit shadow. On a start pulse it decodes the major opcode, forms the effective address from a base register and a signed 16-bit displacement, and checks natural alignment. It then drives a single 32-bit request/grant memory port. Byte, halfword and word accesses take one beat. Doubleword accesses take two beats and quadword accesses take four, stepped by a beat counter.

Loads extract and extend the addressed lane and return the result on a 128-bit writeback bus. Stores place register data in the addressed byte lanes and set matching byte enables. Wide stores take their data from the 128-bit shadow, and every beat carries real register bits. A misaligned access raises a load or store address-error flag for one cycle and never reaches memory. A completed access raises a done pulse once, after its final beat is granted.

Top module: `wide_lsu`

## Requirements
- R1: Opcodes 0x20 (signed byte load), 0x21 (signed half load), 0x23 (word load), 0x24 (unsigned byte load), 0x25 (unsigned half load), 0x37 (64-bit load), 0x1E (128-bit load), 0x28 (byte store), 0x29 (half store), 0x2B (word store), 0x3F (64-bit store) and 0x1F (128-bit store) are accepted. Any other opcode on a start pulse causes no request, no done pulse and no exception, even at an odd address.
- R2: The effective address is base_i plus offset_i sign-extended to 32 bits. Beat k is requested at the word-aligned effective address plus 4*k.
- R3: Byte and half loads take the lane selected by address bits [1:0], little-endian. Opcodes 0x20/0x21 sign-extend to 32 bits and 0x24/0x25 zero-extend. Narrow and word loads place the result in wb_data_o[31:0] with bits [127:32] zero.
- R4: A byte store drives byte enable 1<<addr[1:0]. A half store drives 4'b0011 or 4'b1100 according to addr[1]. A word store drives 4'b1111. The addressed lanes carry st_reg_i, and memory bytes outside them are not modified.
- R5: A 64-bit load takes 2 beats and a 128-bit load takes 4 beats. The word at the lowest address lands in wb_data_o[31:0], the next in [63:32], and so on. A 64-bit load returns zero in [127:64].
- R6: A 64-bit store takes 2 beats and a 128-bit store takes 4 beats, each with byte enable 4'b1111. Beat k carries st_wide_i[32k+31:32k], so no upper beat is zero-filled.
- R7: mem_req_o stays high with a stable address, data and byte enables until mem_gnt_i. Each granted cycle completes exactly one beat.
- R8: Alignment must be natural: 2 bytes for half, 4 for word, 8 for 64-bit and 16 for 128-bit. A misaligned load raises adel_o and a misaligned store raises ades_o, for one cycle, one cycle after the start. Neither flag is followed by a request or a done pulse.
- R9: done_o pulses for exactly one cycle, in the cycle after the last beat's grant. The writeback data is valid from that cycle until the next accepted load.
- R10: A start pulse that arrives while an access is in progress is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| start_i | input | 1 | Issue pulse for one memory instruction |
| opcode_i | input | 6 | Major opcode |
| base_i | input | 32 | Base register value |
| offset_i | input | 16 | Signed displacement |
| st_reg_i | input | 32 | Store data from the 32-bit register file |
| st_wide_i | input | 128 | Store data from the 128-bit register shadow |
| mem_req_o | output | 1 | Beat request |
| mem_we_o | output | 1 | Beat is a write |
| mem_addr_o | output | 32 | Word-aligned beat address |
| mem_wdata_o | output | 32 | Beat write data |
| mem_be_o | output | 4 | Beat byte enables |
| mem_gnt_i | input | 1 | Beat grant; read data is valid in the same cycle |
| mem_rdata_i | input | 32 | Beat read data |
| wb_data_o | output | 128 | Load writeback value |
| done_o | output | 1 | Completion pulse |
| adel_o | output | 1 | Misaligned load flag |
| ades_o | output | 1 | Misaligned store flag |

## Verification
The first request appears in the cycle after the start edge. done_o follows one cycle after the edge that samples the last grant, and an address-error flag appears one cycle after the start edge. The bench records the cycle number of every start, every grant it issues and every output pulse. It compares these numbers instead of sampling at fixed offsets, so the grant stalls of zero, one or two cycles in the vector table move the expected done cycle without breaking the checks. Every output is sampled on the falling edge, half a cycle away from the registers that drive it.

// File: rtl/wlsu_pkg.sv
`timescale 1ns/1ps
package wlsu_pkg;

  typedef enum logic [2:0] {
    SZ_B = 3'd0,
    SZ_H = 3'd1,
    SZ_W = 3'd2,
    SZ_D = 3'd3,
    SZ_Q = 3'd4
  } acc_size_e;

  typedef struct packed {
    logic      valid;
    logic      store;
    logic      sext;
    acc_size_e size;
  } acc_dec_t;

  localparam logic [5:0] OPC_LB  = 6'h20;
  localparam logic [5:0] OPC_LH  = 6'h21;
  localparam logic [5:0] OPC_LW  = 6'h23;
  localparam logic [5:0] OPC_LBU = 6'h24;
  localparam logic [5:0] OPC_LHU = 6'h25;
  localparam logic [5:0] OPC_LD  = 6'h37;
  localparam logic [5:0] OPC_LQ  = 6'h1E;
  localparam logic [5:0] OPC_SB  = 6'h28;
  localparam logic [5:0] OPC_SH  = 6'h29;
  localparam logic [5:0] OPC_SW  = 6'h2B;
  localparam logic [5:0] OPC_SD  = 6'h3F;
  localparam logic [5:0] OPC_SQ  = 6'h1F;

  function automatic acc_dec_t decode_op(input logic [5:0] op);
    acc_dec_t d;
    d.valid = 1'b1;
    d.store = 1'b0;
    d.sext  = 1'b0;
    d.size  = SZ_W;
    case (op)
      OPC_LB:  begin d.size = SZ_B; d.sext = 1'b1; end
      OPC_LH:  begin d.size = SZ_H; d.sext = 1'b1; end
      OPC_LW:  d.size = SZ_W;
      OPC_LBU: d.size = SZ_B;
      OPC_LHU: d.size = SZ_H;
      OPC_LD:  d.size = SZ_D;
      OPC_LQ:  d.size = SZ_Q;
      OPC_SB:  begin d.size = SZ_B; d.store = 1'b1; end
      OPC_SH:  begin d.size = SZ_H; d.store = 1'b1; end
      OPC_SW:  begin d.size = SZ_W; d.store = 1'b1; end
      OPC_SD:  begin d.size = SZ_D; d.store = 1'b1; end
      OPC_SQ:  begin d.size = SZ_Q; d.store = 1'b1; end
      default: d.valid = 1'b0;
    endcase
    return d;
  endfunction

endpackage

// File: rtl/lsu_agen.sv
`timescale 1ns/1ps
module lsu_agen
  import wlsu_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int OFF_W  = 16
) (
  input  logic [ADDR_W-1:0] base_i,
  input  logic [OFF_W-1:0]  off_i,
  input  acc_size_e         size_i,
  output logic [ADDR_W-1:0] ea_o,
  output logic              misal_o
);

  assign ea_o = base_i + {{(ADDR_W-OFF_W){off_i[OFF_W-1]}}, off_i};

  always_comb begin
    case (size_i)
      SZ_H:    misal_o = ea_o[0];
      SZ_W:    misal_o = |ea_o[1:0];
      SZ_D:    misal_o = |ea_o[2:0];
      SZ_Q:    misal_o = |ea_o[3:0];
      default: misal_o = 1'b0;
    endcase
  end

endmodule

// File: rtl/lsu_store_lane.sv
`timescale 1ns/1ps
module lsu_store_lane
  import wlsu_pkg::*;
#(
  parameter int WORD_W = 32,
  parameter int WIDE_W = 128,
  localparam int LANES  = WORD_W / 8,
  localparam int LO_W   = $clog2(LANES),
  localparam int BEAT_W = $clog2(WIDE_W / WORD_W)
) (
  input  acc_size_e         size_i,
  input  logic [LO_W-1:0]   lo_i,
  input  logic [BEAT_W-1:0] beat_i,
  input  logic [WORD_W-1:0] reg_i,
  input  logic [WIDE_W-1:0] wide_i,
  output logic [WORD_W-1:0] wdata_o,
  output logic [LANES-1:0]  be_o
);

  logic [LO_W-1:0] half_lo;
  assign half_lo = {lo_i[LO_W-1:1], 1'b0};

  always_comb begin
    case (size_i)
      SZ_B: begin
        wdata_o = {LANES{reg_i[7:0]}};
        be_o    = LANES'(1) << lo_i;
      end
      SZ_H: begin
        wdata_o = {(LANES/2){reg_i[15:0]}};
        be_o    = LANES'(3) << half_lo;
      end
      SZ_W: begin
        wdata_o = reg_i;
        be_o    = '1;
      end
      default: begin
        // wide beats walk up the shadow register, lowest word first
        wdata_o = wide_i[WORD_W*int'(beat_i) +: WORD_W];
        be_o    = '1;
      end
    endcase
  end

endmodule

// File: rtl/lsu_load_fmt.sv
`timescale 1ns/1ps
module lsu_load_fmt
  import wlsu_pkg::*;
#(
  parameter int WORD_W = 32,
  localparam int LANES = WORD_W / 8,
  localparam int LO_W  = $clog2(LANES)
) (
  input  acc_size_e         size_i,
  input  logic              sext_i,
  input  logic [LO_W-1:0]   lo_i,
  input  logic [WORD_W-1:0] rdata_i,
  output logic [WORD_W-1:0] word_o
);

  logic [7:0]  byte_sel;
  logic [15:0] half_sel;

  assign byte_sel = rdata_i[8*int'(lo_i) +: 8];
  assign half_sel = rdata_i[16*int'(lo_i[LO_W-1:1]) +: 16];

  always_comb begin
    case (size_i)
      SZ_B:    word_o = {{(WORD_W-8){sext_i & byte_sel[7]}}, byte_sel};
      SZ_H:    word_o = {{(WORD_W-16){sext_i & half_sel[15]}}, half_sel};
      default: word_o = rdata_i;
    endcase
  end

endmodule

// File: rtl/wide_lsu.sv
`timescale 1ns/1ps
module wide_lsu
  import wlsu_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int WORD_W = 32,
  parameter int WIDE_W = 128,
  parameter int OFF_W  = 16
) (
  input  logic                  clk_i,
  input  logic                  rst_ni,
  input  logic                  start_i,
  input  logic [5:0]            opcode_i,
  input  logic [ADDR_W-1:0]     base_i,
  input  logic [OFF_W-1:0]      offset_i,
  input  logic [WORD_W-1:0]     st_reg_i,
  input  logic [WIDE_W-1:0]     st_wide_i,
  output logic                  mem_req_o,
  output logic                  mem_we_o,
  output logic [ADDR_W-1:0]     mem_addr_o,
  output logic [WORD_W-1:0]     mem_wdata_o,
  output logic [WORD_W/8-1:0]   mem_be_o,
  input  logic                  mem_gnt_i,
  input  logic [WORD_W-1:0]     mem_rdata_i,
  output logic [WIDE_W-1:0]     wb_data_o,
  output logic                  done_o,
  output logic                  adel_o,
  output logic                  ades_o
);

  localparam int LANES     = WORD_W / 8;
  localparam int LO_W      = $clog2(LANES);
  localparam int BEATS_MAX = WIDE_W / WORD_W;
  localparam int BEAT_W    = $clog2(BEATS_MAX);
  localparam int BEATS_D   = 64 / WORD_W;

  acc_dec_t          dec_in, dec_q;
  logic [ADDR_W-1:0] ea;
  logic              misal;
  logic              accept, go, beat_done, last_beat;
  logic [BEAT_W-1:0] last_in;

  logic              busy_q, done_q, adel_q, ades_q;
  logic [ADDR_W-1:0] word_addr_q;
  logic [LO_W-1:0]   lo_q;
  logic [BEAT_W-1:0] beat_q, last_q;
  logic [WORD_W-1:0] st_reg_q;
  logic [WIDE_W-1:0] st_wide_q;
  logic [WORD_W-1:0] ld_word;
  logic [WORD_W-1:0] word_q [BEATS_MAX];

  assign dec_in = decode_op(opcode_i);
  assign accept = start_i & ~busy_q & dec_in.valid;
  assign go     = accept & ~misal;

  lsu_agen #(.ADDR_W(ADDR_W), .OFF_W(OFF_W)) u_agen (
    .base_i  (base_i),
    .off_i   (offset_i),
    .size_i  (dec_in.size),
    .ea_o    (ea),
    .misal_o (misal)
  );

  always_comb begin
    case (dec_in.size)
      SZ_D:    last_in = BEAT_W'(BEATS_D - 1);
      SZ_Q:    last_in = BEAT_W'(BEATS_MAX - 1);
      default: last_in = '0;
    endcase
  end

  assign beat_done = busy_q & mem_gnt_i;
  assign last_beat = (beat_q == last_q);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      busy_q      <= 1'b0;
      done_q      <= 1'b0;
      adel_q      <= 1'b0;
      ades_q      <= 1'b0;
      dec_q       <= '0;
      word_addr_q <= '0;
      lo_q        <= '0;
      beat_q      <= '0;
      last_q      <= '0;
      st_reg_q    <= '0;
      st_wide_q   <= '0;
    end else begin
      done_q <= 1'b0;
      adel_q <= 1'b0;
      ades_q <= 1'b0;
      if (accept && misal) begin
        adel_q <= ~dec_in.store;
        ades_q <= dec_in.store;
      end
      if (go) begin
        busy_q      <= 1'b1;
        dec_q       <= dec_in;
        word_addr_q <= {ea[ADDR_W-1:LO_W], {LO_W{1'b0}}};
        lo_q        <= ea[LO_W-1:0];
        beat_q      <= '0;
        last_q      <= last_in;
        st_reg_q    <= st_reg_i;
        st_wide_q   <= st_wide_i;
      end else if (beat_done) begin
        if (last_beat) begin
          busy_q <= 1'b0;
          done_q <= 1'b1;
        end else begin
          beat_q <= beat_q + 1'b1;
        end
      end
    end
  end

  lsu_store_lane #(.WORD_W(WORD_W), .WIDE_W(WIDE_W)) u_store_lane (
    .size_i  (dec_q.size),
    .lo_i    (lo_q),
    .beat_i  (beat_q),
    .reg_i   (st_reg_q),
    .wide_i  (st_wide_q),
    .wdata_o (mem_wdata_o),
    .be_o    (mem_be_o)
  );

  lsu_load_fmt #(.WORD_W(WORD_W)) u_load_fmt (
    .size_i  (dec_q.size),
    .sext_i  (dec_q.sext),
    .lo_i    (lo_q),
    .rdata_i (mem_rdata_i),
    .word_o  (ld_word)
  );

  // one capture register per beat; a new load clears all of them
  for (genvar g = 0; g < BEATS_MAX; g++) begin : g_word
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        word_q[g] <= '0;
      end else if (go && !dec_in.store) begin
        word_q[g] <= '0;
      end else if (beat_done && !dec_q.store && beat_q == BEAT_W'(g)) begin
        word_q[g] <= ld_word;
      end
    end
    assign wb_data_o[g*WORD_W +: WORD_W] = word_q[g];
  end

  assign mem_req_o  = busy_q;
  assign mem_we_o   = busy_q & dec_q.store;
  assign mem_addr_o = word_addr_q + (ADDR_W'(beat_q) << LO_W);
  assign done_o     = done_q;
  assign adel_o     = adel_q;
  assign ades_o     = ades_q;

  AST_REQ_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_req_o && !mem_gnt_i |=> mem_req_o && $stable(mem_addr_o) && $stable(mem_wdata_o) && $stable(mem_be_o)); // R7
  AST_ADDR_STEP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_req_o && mem_gnt_i |=> !mem_req_o || (mem_addr_o == $past(mem_addr_o) + ADDR_W'(LANES))); // R2
  AST_DONE_AFTER_GNT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> $past(mem_req_o && mem_gnt_i)); // R9
  AST_DONE_PULSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o); // R9
  AST_EXC_NO_ACCESS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (adel_o || ades_o) |-> !mem_req_o && !done_o); // R8
  AST_EXC_EXCL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(adel_o && ades_o)); // R8
  AST_BYTE_BE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_we_o && dec_q.size == SZ_B |-> $countones(mem_be_o) == 1); // R4
  AST_HALF_BE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_we_o && dec_q.size == SZ_H |-> $countones(mem_be_o) == 2); // R4
  AST_WIDE_BE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_we_o && (dec_q.size == SZ_D || dec_q.size == SZ_Q) |-> &mem_be_o); // R6

endmodule

// File: tb/wide_lsu_bench.sv
`timescale 1ns/1ps
module wide_lsu_bench;

  localparam logic [127:0] WIDE = 128'hF0E1D2C3_B4A59687_78695A4B_3C2D1E0F;

  typedef struct packed {
    logic [5:0]  op;
    logic [31:0] base;
    logic [15:0] off;
    logic [31:0] st_reg;
    logic [1:0]  stall;
    logic [1:0]  exc;     // 0 none, 1 load error, 2 store error
  } vec_t;

  localparam int NV = 19;
  localparam vec_t VECS [NV] = '{
    '{6'h20, 32'h40, 16'h0003, 32'h0,         2'd0, 2'd0},  // R3 LB negative
    '{6'h20, 32'h80, 16'h0003, 32'h0,         2'd1, 2'd0},  // R3 LB positive
    '{6'h24, 32'h40, 16'hFFFD, 32'h0,         2'd0, 2'd0},  // R3 R2 LBU neg offset
    '{6'h21, 32'h50, 16'h0002, 32'h0,         2'd0, 2'd0},  // R3 LH
    '{6'h25, 32'h50, 16'h0006, 32'h0,         2'd1, 2'd0},  // R3 LHU
    '{6'h23, 32'h60, 16'h0004, 32'h0,         2'd2, 2'd0},  // R3 LW
    '{6'h37, 32'h80, 16'h0008, 32'h0,         2'd1, 2'd0},  // R5 LD
    '{6'h1E, 32'h90, 16'h0010, 32'h0,         2'd2, 2'd0},  // R5 LQ
    '{6'h28, 32'h20, 16'h0001, 32'h123456CD,  2'd0, 2'd0},  // R4 SB
    '{6'h28, 32'h23, 16'h0000, 32'h9ABCDE5A,  2'd1, 2'd0},  // R4 SB lane 3
    '{6'h29, 32'h20, 16'h0006, 32'h55AA7E81,  2'd0, 2'd0},  // R4 SH upper
    '{6'h2B, 32'h30, 16'hFFFC, 32'hDEADBEEF,  2'd1, 2'd0},  // R4 SW
    '{6'h3F, 32'h38, 16'h0000, 32'h0,         2'd0, 2'd0},  // R6 SD
    '{6'h1F, 32'hC0, 16'h0000, 32'h0,         2'd1, 2'd0},  // R6 SQ
    '{6'h21, 32'h51, 16'h0000, 32'h0,         2'd0, 2'd1},  // R8 LH odd
    '{6'h23, 32'h62, 16'h0000, 32'h0,         2'd0, 2'd1},  // R8 LW
    '{6'h37, 32'h84, 16'h0000, 32'h0,         2'd0, 2'd1},  // R8 LD
    '{6'h2B, 32'h2A, 16'h0000, 32'h11111111,  2'd0, 2'd2},  // R8 SW
    '{6'h1F, 32'hC0, 16'h0008, 32'h0,         2'd0, 2'd2}   // R8 SQ
  };

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         start = 1'b0;
  logic [5:0]   opcode = '0;
  logic [31:0]  base = '0;
  logic [15:0]  off = '0;
  logic [31:0]  st_reg = '0;
  logic [127:0] st_wide = '0;
  logic         mem_req, mem_we, gnt = 1'b0;
  logic [31:0]  mem_addr, mem_wdata, rdata = '0;
  logic [3:0]   mem_be;
  logic [127:0] wb_data;
  logic         done, adel, ades;

  int checks = 0, errors = 0;
  int cyc = 0, stall_cycles = 0, stall_ctr = 0;
  int done_cnt, adel_cnt, ades_cnt, gnt_cnt;
  int done_cyc, exc_cyc, gnt_cyc, start_cyc;
  logic [7:0] mem_b [256];

  wide_lsu u_wide_lsu (
    .clk_i(clk), .rst_ni(rst_n), .start_i(start), .opcode_i(opcode),
    .base_i(base), .offset_i(off), .st_reg_i(st_reg), .st_wide_i(st_wide),
    .mem_req_o(mem_req), .mem_we_o(mem_we), .mem_addr_o(mem_addr),
    .mem_wdata_o(mem_wdata), .mem_be_o(mem_be), .mem_gnt_i(gnt),
    .mem_rdata_i(rdata), .wb_data_o(wb_data), .done_o(done),
    .adel_o(adel), .ades_o(ades)
  );

  always #10 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  function automatic logic [7:0] pat(input int a);
    return 8'(a & 255) ^ 8'hC3;
  endfunction

  function automatic int size_bytes(input logic [5:0] op);
    case (op)
      6'h20, 6'h24, 6'h28: return 1;
      6'h21, 6'h25, 6'h29: return 2;
      6'h23, 6'h2B:        return 4;
      6'h37, 6'h3F:        return 8;
      6'h1E, 6'h1F:        return 16;
      default:             return 0;
    endcase
  endfunction

  function automatic bit is_store(input logic [5:0] op);
    return op inside {6'h28, 6'h29, 6'h2B, 6'h3F, 6'h1F};
  endfunction

  task automatic init_mem();
    for (int i = 0; i < 256; i++) mem_b[i] = pat(i);
  endtask

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [127:0] act, input logic [127:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: got %h expected %h", req, what, act, exp);
    end
  endtask

  // memory model and output monitor, both on the falling edge
  always @(negedge clk) begin
    if (done) begin done_cnt++; done_cyc = cyc; end
    if (adel) begin adel_cnt++; exc_cyc = cyc; end
    if (ades) begin ades_cnt++; exc_cyc = cyc; end
    if (mem_req && stall_ctr >= stall_cycles) begin
      int a;
      a = int'(mem_addr[7:0]);
      rdata = {mem_b[(a+3)&255], mem_b[(a+2)&255], mem_b[(a+1)&255], mem_b[a]};
      if (mem_we)
        for (int b = 0; b < 4; b++)
          if (mem_be[b]) mem_b[(a+b)&255] = mem_wdata[8*b +: 8];
      gnt = 1'b1;
      gnt_cnt++;
      gnt_cyc = cyc;
      stall_ctr = 0;
    end else begin
      gnt = 1'b0;
      if (mem_req) stall_ctr++;
      else stall_ctr = 0;
    end
  end

  task automatic issue(input logic [5:0] op, input logic [31:0] b, input logic [15:0] o,
                       input logic [31:0] sr);
    @(negedge clk);
    start = 1'b1; opcode = op; base = b; off = o; st_reg = sr; st_wide = WIDE;
    start_cyc = cyc;
    @(negedge clk);
    start = 1'b0;
  endtask

  task automatic clear_counts();
    done_cnt = 0; adel_cnt = 0; ades_cnt = 0; gnt_cnt = 0;
  endtask

  task automatic run_vec(input vec_t v);
    int ea, n, beats;
    logic [127:0] exp, src;
    bit ok;
    string rq;
    init_mem();
    stall_cycles = int'(v.stall);
    clear_counts();
    issue(v.op, v.base, v.off, v.st_reg);
    repeat (25) @(negedge clk);
    ea = int'(v.base + {{16{v.off[15]}}, v.off});
    n = size_bytes(v.op);
    beats = (v.exc != 0) ? 0 : ((n <= 4) ? 1 : n / 4);
    rq = (v.exc != 0) ? "R8" : (n > 4 ? (is_store(v.op) ? "R6" : "R5") : (is_store(v.op) ? "R4" : "R3"));
    chk(adel_cnt == ((v.exc == 1) ? 1 : 0), "R8", "load error count", 128'(adel_cnt), 128'(v.exc == 1));
    chk(ades_cnt == ((v.exc == 2) ? 1 : 0), "R8", "store error count", 128'(ades_cnt), 128'(v.exc == 2));
    chk(gnt_cnt == beats, rq, "beat count", 128'(gnt_cnt), 128'(beats));
    chk(done_cnt == ((v.exc == 0) ? 1 : 0), "R9", "done count", 128'(done_cnt), 128'(v.exc == 0));
    if (v.exc != 0) begin
      chk(exc_cyc == start_cyc + 1, "R8", "error cycle", 128'(exc_cyc), 128'(start_cyc + 1));
    end else begin
      chk(done_cyc == gnt_cyc + 1, "R9", "done cycle", 128'(done_cyc), 128'(gnt_cyc + 1));
      if (!is_store(v.op)) begin
        exp = '0;
        for (int k = 0; k < n; k++) exp[8*k +: 8] = pat(ea + k);
        if (v.op == 6'h20) exp[31:8]  = {24{exp[7]}};
        if (v.op == 6'h21) exp[31:16] = {16{exp[15]}};
        chk(wb_data === exp, rq, "load data", wb_data, exp);
      end else begin
        src = (n <= 4) ? {96'h0, v.st_reg} : WIDE;
        ok = 1'b1;
        for (int k = 0; k < n; k++)
          if (mem_b[(ea+k)&255] !== src[8*k +: 8]) ok = 1'b0;
        // neighbouring bytes within the touched word(s) stay untouched
        for (int k = (ea & ~3); k < ((ea + n + 3) & ~3); k++)
          if ((k < ea || k >= ea + n) && mem_b[k&255] !== pat(k)) ok = 1'b0;
        if (mem_b[(ea-1)&255] !== pat(ea-1) || mem_b[(ea+n)&255] !== pat(ea+n)) ok = 1'b0;
        chk(ok, rq, "store bytes",
            {mem_b[(ea+3)&255], mem_b[(ea+2)&255], mem_b[(ea+1)&255], mem_b[ea&255]}, src);
      end
    end
  endtask

  initial begin
    init_mem();
    repeat (3) @(negedge clk);
    // reset state
    chk(!mem_req && !done && !adel && !ades && wb_data == '0, "R9", "reset outputs",
        {mem_req, done, adel, ades}, '0);
    rst_n = 1'b1;
    @(negedge clk);
    chk(!mem_req && !done, "R7", "idle after reset", {mem_req, done}, '0);

    for (int i = 0; i < NV; i++) run_vec(VECS[i]);

    // R1: unsupported opcodes, including at an odd address
    init_mem();
    stall_cycles = 0;
    clear_counts();
    issue(6'h08, 32'h41, 16'h0, 32'h0);
    issue(6'h00, 32'h40, 16'h0, 32'h0);
    issue(6'h2F, 32'h43, 16'h0, 32'h0);
    repeat (10) @(negedge clk);
    chk(gnt_cnt == 0 && done_cnt == 0 && adel_cnt == 0 && ades_cnt == 0, "R1",
        "unsupported opcode activity", 128'(gnt_cnt + done_cnt + adel_cnt + ades_cnt), '0);

    // R10: start while busy is dropped
    init_mem();
    stall_cycles = 2;
    clear_counts();
    issue(6'h1E, 32'hA0, 16'h0, 32'h0);
    issue(6'h28, 32'h10, 16'h0, 32'h000000EE);
    repeat (25) @(negedge clk);
    chk(gnt_cnt == 4, "R10", "beats with overlap start", 128'(gnt_cnt), 128'd4);
    chk(done_cnt == 1, "R10", "done with overlap start", 128'(done_cnt), 128'd1);
    chk(mem_b[16] === pat(16), "R10", "dropped store byte", 128'(mem_b[16]), 128'(pat(16)));

    // R9: writeback holds across a later store and an error
    begin
      logic [127:0] held;
      held = wb_data;
      stall_cycles = 0;
      issue(6'h2B, 32'h20, 16'h0, 32'h01020304);
      issue(6'h23, 32'h21, 16'h0, 32'h0);
      repeat (8) @(negedge clk);
      chk(wb_data === held, "R9", "writeback hold", wb_data, held);
    end

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule